// File: doc/BRIEF.md
# Two-slot event mailbox

This block hands single data words from a writer clock domain to a reader clock domain with event semantics. The writer is never made to wait. A new word may replace a word the reader has not yet taken. The reader only ever receives a word it has not received before. If nothing new is present, its request simply stays pending.

Storage is two data slots. Coordination uses two one-bit flags: one owned by the writer and one owned by the reader. Each flag reaches the other domain through a short flop chain, so no arbiter or mutual-exclusion element is needed. A write fills the slot opposite the reader flag as last seen by the writer, then sets the writer flag to that slot index. A word counts as fresh in the reader domain while the synchronized writer flag differs from the reader flag. Taking it toggles the reader flag.

Because each flag takes time to cross, a write that lands just after a read can go unflagged. The mailbox therefore holds between zero and one pending item.

Top module: `evt_mailbox2`

## Requirements
- R1: After reset, `rd_valid` is 0 and `rd_data` is 0, and a held `rd_req` produces no `rd_valid` until a first write occurs.
- R2: Every `wclk` cycle with `wr_en` high accepts `wr_data`, with no back-pressure. A delivered word equals the word that was written.
- R3: When several writes occur with no read between them, the next read delivers the most recent of them.
- R4: Each written word is delivered at most once. While `rd_req` stays high after a delivery, `rd_valid` stays 0 until a new write is flagged.
- R5: `rd_valid` is a single-cycle pulse, raised only in the cycle after `rd_req` was sampled high. `rd_data` changes only together with `rd_valid` and holds its value otherwise.
- R6: A write into an idle mailbox is delivered on the third `rclk` rising edge after the `wclk` edge that captured it, provided `rd_req` is held high. A word already flagged as fresh is delivered on the first `rclk` edge that samples `rd_req` high.
- R7: A write captured within two `wclk` edges after a delivery is not flagged as fresh, so no `rd_valid` follows it. A write made once the writer has observed that delivery is flagged and delivered.
- R8: For a stream of strictly increasing written words, the delivered words are strictly increasing and each is one of the written words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Writer domain clock |
| wrst_n | input | 1 | Writer domain asynchronous reset, active low |
| wr_en | input | 1 | Write strobe, one word per cycle |
| wr_data | input | DW | Word to write |
| rclk | input | 1 | Reader domain clock |
| rrst_n | input | 1 | Reader domain asynchronous reset, active low |
| rd_req | input | 1 | Read request, level sensitive |
| rd_valid | output | 1 | One-cycle pulse marking a delivered word |
| rd_data | output | DW | Delivered word, held between deliveries |

## Verification
A write needs three `rclk` edges to become a delivery: two synchronizer flops, then the output register. A word that is already fresh needs one `rclk` edge after `rd_req` is seen. The reader flag needs two `wclk` edges to reach the writer. The two clocks run at 10 ns and 13 ns with offset phases, so their edges never coincide. Each read check counts `rclk` rising edges from the capturing `wclk` edge and samples 1 ns after each edge, so it can demand the exact edge count. The zero-capacity case is reached by issuing the next write at the first falling `wclk` edge after a delivery is observed, which places its capture inside the two-edge window.

// File: rtl/evt_mailbox2.sv
module evt_mailbox2 #(
  parameter int DW   = 16,
  parameter int SYNC = 2
) (
  input  logic          wclk,
  input  logic          wrst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rclk,
  input  logic          rrst_n,
  input  logic          rd_req,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data
);

  logic [DW-1:0]   slot0, slot1;
  logic            w_bit, r_bit;
  logic [SYNC-1:0] r_pipe, w_pipe;
  logic            r_seen, w_seen, fresh, take;

  assign r_seen = r_pipe[SYNC-1];
  assign w_seen = w_pipe[SYNC-1];
  assign fresh  = w_seen ^ r_bit;
  assign take   = rd_req & fresh;

  // reader flag into writer domain
  always_ff @(posedge wclk or negedge wrst_n)
    if (!wrst_n) r_pipe <= '0;
    else         r_pipe <= {r_pipe[SYNC-2:0], r_bit};

  // writer flag into reader domain
  always_ff @(posedge rclk or negedge rrst_n)
    if (!rrst_n) w_pipe <= '0;
    else         w_pipe <= {w_pipe[SYNC-2:0], w_bit};

  // writer: fill the slot the reader is not holding, then point at it
  always_ff @(posedge wclk or negedge wrst_n)
    if (!wrst_n) begin
      w_bit <= 1'b0;
      slot0 <= '0;
      slot1 <= '0;
    end else if (wr_en) begin
      if (r_seen) slot0 <= wr_data;
      else        slot1 <= wr_data;
      w_bit <= ~r_seen;
    end

  // reader: take only while the writer flag differs from the reader flag
  always_ff @(posedge rclk or negedge rrst_n)
    if (!rrst_n) begin
      r_bit    <= 1'b0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= take;
      if (take) begin
        r_bit   <= ~r_bit;
        rd_data <= w_seen ? slot1 : slot0;
      end
    end

endmodule

// File: rtl/evt_mailbox2_chk.sv
module evt_mailbox2_chk #(
  parameter int DW = 16
) (
  input logic          wclk,
  input logic          wrst_n,
  input logic          wr_en,
  input logic          w_bit,
  input logic          rclk,
  input logic          rrst_n,
  input logic          rd_req,
  input logic          rd_valid,
  input logic [DW-1:0] rd_data
);

  a_r1_quiet_in_reset: assert property (@(posedge rclk) !rrst_n |-> !rd_valid);

  a_r5_valid_after_req: assert property (@(posedge rclk) disable iff (!rrst_n)
    rd_valid |-> $past(rd_req));

  a_r5_single_pulse: assert property (@(posedge rclk) disable iff (!rrst_n)
    rd_valid |=> !rd_valid);

  a_r5_data_hold: assert property (@(posedge rclk) disable iff (!rrst_n)
    !rd_valid |-> $stable(rd_data));

  a_r2_flag_moves_only_on_write: assert property (@(posedge wclk) disable iff (!wrst_n)
    !wr_en |=> $stable(w_bit));

endmodule

bind evt_mailbox2 evt_mailbox2_chk #(.DW(DW)) u_chk (
  .wclk(wclk), .wrst_n(wrst_n), .wr_en(wr_en), .w_bit(w_bit),
  .rclk(rclk), .rrst_n(rrst_n), .rd_req(rd_req),
  .rd_valid(rd_valid), .rd_data(rd_data)
);

// File: tb/tb_evt_mailbox2.sv
`timescale 1ns/100ps
module tb_evt_mailbox2;
  localparam real CLK_PERIOD  = 10.0;
  localparam real RCLK_PERIOD = 13.0;
  localparam int  DW = 16;

  logic          wclk = 1'b0, rclk = 1'b0;
  logic          wrst_n = 1'b0, rrst_n = 1'b0;
  logic          wr_en = 1'b0, rd_req = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic          rd_valid;
  logic [DW-1:0] rd_data;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  evt_mailbox2 #(.DW(DW)) dut (
    .wclk(wclk), .wrst_n(wrst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rclk(rclk), .rrst_n(rrst_n), .rd_req(rd_req),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  initial forever #(CLK_PERIOD/2) wclk = ~wclk;
  initial begin
    #(RCLK_PERIOD/4);
    forever #(RCLK_PERIOD/2) rclk = ~rclk;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic wr_capture(input int v);
    @(negedge wclk);
    wr_en   = 1'b1;
    wr_data = DW'(v);
    @(posedge wclk);
    wr_en <= 1'b0;
  endtask

  task automatic wait_valid(input int max, output int n, output bit seen);
    n = 0;
    seen = 1'b0;
    while (n < max && !seen) begin
      @(posedge rclk); #1;
      n++;
      if (rd_valid) seen = 1'b1;
    end
  endtask

  task automatic count_valids(input int cycles, output int cnt);
    cnt = 0;
    for (int i = 0; i < cycles; i++) begin
      @(posedge rclk); #1;
      if (rd_valid) cnt++;
    end
  endtask

  task automatic t_reset;
    int cnt;
    chk(rd_valid == 1'b0, "R1 valid after reset", int'(rd_valid), 0);
    chk(rd_data == '0, "R1 data after reset", int'(rd_data), 0);
    rd_req = 1'b1;
    count_valids(12, cnt);
    chk(cnt == 0, "R1 stall before first write", cnt, 0);
  endtask

  task automatic t_single;
    int n, cnt; bit seen;
    wr_capture(16'h0123);
    wait_valid(10, n, seen);
    chk(seen, "R6 delivery seen", int'(seen), 1);
    chk(n == 3, "R6 three reader edges", n, 3);
    chk(rd_data == 16'h0123, "R2 delivered word", int'(rd_data), 16'h0123);
    @(posedge rclk); #1;
    chk(!rd_valid, "R5 single pulse", int'(rd_valid), 0);
    count_valids(15, cnt);
    chk(cnt == 0, "R4 no repeat delivery", cnt, 0);
    chk(rd_data == 16'h0123, "R5 data held", int'(rd_data), 16'h0123);
  endtask

  task automatic t_burst;
    int n, cnt; bit seen;
    rd_req = 1'b0;
    for (int i = 0; i < 8; i++) begin
      @(negedge wclk);
      wr_en   = 1'b1;
      wr_data = DW'(16'h0200 + i);
    end
    @(negedge wclk);
    wr_en = 1'b0;
    count_valids(10, cnt);
    chk(cnt == 0, "R5 no valid without request", cnt, 0);
    rd_req = 1'b1;
    wait_valid(10, n, seen);
    chk(seen && n == 1, "R6 fresh word on first sampled request", n, 1);
    chk(rd_data == 16'h0207, "R3 newest of burst", int'(rd_data), 16'h0207);
    count_valids(10, cnt);
    chk(cnt == 0, "R4 burst delivered once", cnt, 0);
  endtask

  task automatic t_cap_zero;
    int n, cnt; bit seen;
    wr_capture(16'h0300);
    wait_valid(10, n, seen);
    chk(seen && rd_data == 16'h0300, "R7 first word", int'(rd_data), 16'h0300);
    wr_capture(16'h03AA);
    count_valids(12, cnt);
    chk(cnt == 0, "R7 early write not flagged", cnt, 0);
    wr_capture(16'h03BB);
    wait_valid(10, n, seen);
    chk(seen, "R7 later write flagged", int'(seen), 1);
    chk(rd_data == 16'h03BB, "R7 later write delivered", int'(rd_data), 16'h03BB);
  endtask

  task automatic t_stream;
    int last = 999, got = 0;
    rd_req = 1'b1;
    done = 1'b0;
    fork
      begin
        for (int i = 0; i < 40; i++) begin
          wr_capture(1000 + i);
          repeat (i % 4) @(negedge wclk);
        end
        repeat (20) @(posedge wclk);
        done = 1'b1;
      end
      begin
        while (!done) begin
          @(posedge rclk); #1;
          if (rd_valid) begin
            got++;
            chk(int'(rd_data) > last && int'(rd_data) <= 1039,
                "R8 increasing written word", int'(rd_data), last + 1);
            last = int'(rd_data);
          end
        end
      end
    join
    chk(got >= 5, "R8 stream deliveries", got, 5);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    #(CLK_PERIOD * 3 + 1);
    wrst_n = 1'b1;
    rrst_n = 1'b1;
    repeat (3) @(posedge rclk);
    #1;
    t_reset();
    t_single();
    t_burst();
    t_cap_zero();
    t_stream();
    summary();
  end
endmodule